// File: doc/BRIEF.md
# GEMM Tile Stage Command Sequencer

This block turns one tiled matrix multiply, C = A×B, into an ordered stream of stage commands for a processing-element pipeline. A start pulse captures the three matrix sizes, the three tile sizes, the element width in bytes, the base addresses of A, B and C, and two residency flags. The block then walks every tile and issues one command per pipeline stage: an operand read from external memory, a fetch into the register file, the multiply-accumulate step, a store out of the register file, and a write-back to external memory.

The walk is ordered with the row-tile index outermost, the column-tile index next and the reduction-tile index innermost. The accumulator stays in the register file across the reduction loop, so the store and the write-back are issued only once per output tile, after its last reduction step. An operand that is already resident in local memory has its read dropped from every tile. Commands leave through a valid/ready handshake, and a one-cycle done pulse closes each run.

Top module: `gemm_tile_seq`

## Requirements
- R1: The number of tiles along each dimension is ceil(size / tile size) with a minimum of one; a tile size of zero is treated as one, and a size of zero still gives one tile.
- R2: Tiles are visited with the M tile index outermost, the N tile index in the middle and the K tile index innermost.
- R3: For each tile the stages appear in this order: read A (code 0, operand tag 1), read B (code 1, operand tag 2), fetch (code 2), GEMM (code 3), and only on the last K tile store (code 4) followed by write (code 5); stages other than the two reads carry operand tag 0.
- R4: When the A-resident flag is set no read-A command is issued; when the B-resident flag is set no read-B command is issued.
- R5: Read A carries address A_base + (m·tile_m·K + k·tile_k)·bpe and read B carries B_base + (k·tile_k·N + n·tile_n)·bpe, modulo 2^ADDR_W; fetch, GEMM and store carry address 0.
- R6: The write command carries C_base + (m·tile_m·N + n·tile_n)·bpe, which depends only on m and n.
- R7: Byte counts are tile_m·tile_k·bpe for read A, tile_k·tile_n·bpe for read B, their sum for fetch, tile_m·tile_n·bpe for store and write, and 0 for GEMM.
- R8: The last-K flag is 1 on the GEMM command of the final K tile and 0 on every other command.
- R9: The tile index is 0 for the first tile of a run and rises by one for every (m, n, k) tile.
- R10: While a command is valid and not accepted, it stays valid and all its fields stay unchanged.
- R11: Done is high for exactly one cycle, in the cycle after the final write is accepted, and no command is valid then; a start that arrives during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the current configuration |
| dim_m | input | DIM_W | Rows of A and C |
| dim_k | input | DIM_W | Reduction length |
| dim_n | input | DIM_W | Columns of B and C |
| tile_m | input | DIM_W | Tile rows |
| tile_k | input | DIM_W | Tile reduction length |
| tile_n | input | DIM_W | Tile columns |
| elem_bytes | input | BPE_W | Bytes per element |
| a_base | input | ADDR_W | Base address of A |
| b_base | input | ADDR_W | Base address of B |
| c_base | input | ADDR_W | Base address of C |
| a_resident | input | 1 | A already in local memory |
| b_resident | input | 1 | B already in local memory |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_stage | output | 3 | Stage code |
| cmd_addr | output | ADDR_W | Command address |
| cmd_bytes | output | BYTE_W | Bytes moved |
| cmd_operand | output | 2 | Operand tag |
| cmd_last_k | output | 1 | Last reduction tile on GEMM |
| cmd_tile | output | IDX_W | Tile index |
| done | output | 1 | Run complete pulse |

## Verification
On every cycle the assertions check that a stalled command holds all its fields, that done lasts one cycle and never overlaps a valid command, that no read-A appears for a resident A, that fetch is always followed by GEMM, that the tile index steps by one after a non-final GEMM, that a non-final GEMM is never followed by a store, and that each dimension offset stays inside its matrix. The exact addresses, byte counts, the M-N-K visiting order, the tile-count rounding and the insensitivity to a start pulse in mid-run are shown only by the bench, which compares every accepted command against a model walk built with ceiling division over several size, tile and residency mixes under random back-pressure.

// File: rtl/gts_pkg.sv
package gts_pkg;

  typedef enum logic [2:0] {
    ST_RD_A  = 3'd0,
    ST_RD_B  = 3'd1,
    ST_FETCH = 3'd2,
    ST_GEMM  = 3'd3,
    ST_STORE = 3'd4,
    ST_WRITE = 3'd5
  } stage_t;

  localparam logic [1:0] OPR_NONE = 2'd0;
  localparam logic [1:0] OPR_A    = 2'd1;
  localparam logic [1:0] OPR_B    = 2'd2;

  // First stage of every tile, given which operands are already local.
  function automatic stage_t tile_entry(input logic a_local, input logic b_local);
    if (!a_local)      return ST_RD_A;
    else if (!b_local) return ST_RD_B;
    else               return ST_FETCH;
  endfunction

endpackage

// File: rtl/gts_dim_walker.sv
// Offset walker for one matrix dimension: steps by the tile size and
// reports whether the current tile is the last one along this dimension.
module gts_dim_walker #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] size,
  input  logic [DIM_W-1:0] tile,
  output logic             is_last
);

  logic [DIM_W-1:0] size_q;
  logic [DIM_W-1:0] tile_q;
  logic [DIM_W-1:0] off_q;
  logic [DIM_W:0]   reach;

  assign reach   = {1'b0, off_q} + {1'b0, tile_q};
  assign is_last = (reach >= {1'b0, size_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      tile_q <= DIM_W'(1);
      off_q  <= '0;
    end else if (load) begin
      size_q <= size;
      tile_q <= tile;
      off_q  <= '0;
    end else if (step) begin
      if (is_last) off_q <= '0;
      else         off_q <= reach[DIM_W-1:0];
    end
  end

  assert_off_range_R1: assert property (@(posedge clk) disable iff (rst)
    (off_q == '0) || (off_q < size_q));

endmodule

// File: rtl/gts_addr_walk.sv
// Incremental address pointers for the A, B and C tiles. Strides are
// multiplied once at load; the walk itself uses only adders.
module gts_addr_walk #(
  parameter int DIM_W  = 16,
  parameter int ADDR_W = 32,
  parameter int BPE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [ADDR_W-1:0] c_base,
  input  logic [DIM_W-1:0]  dim_k,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  tm,
  input  logic [DIM_W-1:0]  tk,
  input  logic [DIM_W-1:0]  tn,
  input  logic [BPE_W-1:0]  bpe,
  input  logic              k_step,
  input  logic              n_step,
  input  logic              m_step,
  output logic [ADDR_W-1:0] a_ptr,
  output logic [ADDR_W-1:0] b_ptr,
  output logic [ADDR_W-1:0] c_ptr
);

  logic [ADDR_W-1:0] s_am, s_ak, s_bk, s_bn, s_cm;
  logic [ADDR_W-1:0] a_row, b_col, c_row, b_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_am <= '0; s_ak <= '0; s_bk <= '0; s_bn <= '0; s_cm <= '0;
      a_row <= '0; b_col <= '0; c_row <= '0; b_start <= '0;
      a_ptr <= '0; b_ptr <= '0; c_ptr <= '0;
    end else if (load) begin
      s_am    <= ADDR_W'(tm) * ADDR_W'(dim_k) * ADDR_W'(bpe);
      s_ak    <= ADDR_W'(tk) * ADDR_W'(bpe);
      s_bk    <= ADDR_W'(tk) * ADDR_W'(dim_n) * ADDR_W'(bpe);
      s_bn    <= ADDR_W'(tn) * ADDR_W'(bpe);
      s_cm    <= ADDR_W'(tm) * ADDR_W'(dim_n) * ADDR_W'(bpe);
      a_row   <= a_base;
      a_ptr   <= a_base;
      b_start <= b_base;
      b_col   <= b_base;
      b_ptr   <= b_base;
      c_row   <= c_base;
      c_ptr   <= c_base;
    end else if (m_step) begin
      a_row <= a_row + s_am;
      a_ptr <= a_row + s_am;
      b_col <= b_start;
      b_ptr <= b_start;
      c_row <= c_row + s_cm;
      c_ptr <= c_row + s_cm;
    end else if (n_step) begin
      a_ptr <= a_row;
      b_col <= b_col + s_bn;
      b_ptr <= b_col + s_bn;
      c_ptr <= c_ptr + s_bn;
    end else if (k_step) begin
      a_ptr <= a_ptr + s_ak;
      b_ptr <= b_ptr + s_bk;
    end
  end

  // The C row only moves when the M tile index moves.
  assert_crow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (n_step && !m_step && !load) |=> $stable(c_row));

  // Within one output tile the C pointer does not move along K.
  assert_cptr_k_R6: assert property (@(posedge clk) disable iff (rst)
    (k_step && !n_step && !m_step && !load) |=> $stable(c_ptr));

endmodule

// File: rtl/gemm_tile_seq.sv
module gemm_tile_seq #(
  parameter int DIM_W  = 16,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 32,
  parameter int BPE_W  = 4,
  parameter int IDX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIM_W-1:0]  dim_m,
  input  logic [DIM_W-1:0]  dim_k,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  tile_m,
  input  logic [DIM_W-1:0]  tile_k,
  input  logic [DIM_W-1:0]  tile_n,
  input  logic [BPE_W-1:0]  elem_bytes,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [ADDR_W-1:0] c_base,
  input  logic              a_resident,
  input  logic              b_resident,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_stage,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_bytes,
  output logic [1:0]        cmd_operand,
  output logic              cmd_last_k,
  output logic [IDX_W-1:0]  cmd_tile,
  output logic              done
);
  import gts_pkg::*;

  logic [DIM_W-1:0] tm_c, tk_c, tn_c;
  assign tm_c = (tile_m == '0) ? DIM_W'(1) : tile_m;
  assign tk_c = (tile_k == '0) ? DIM_W'(1) : tile_k;
  assign tn_c = (tile_n == '0) ? DIM_W'(1) : tile_n;

  logic        busy_q, done_q, a_pin_q, b_pin_q;
  stage_t      stage_q;
  logic [IDX_W-1:0]  tile_q;
  logic [BYTE_W-1:0] a_bytes_q, b_bytes_q, c_bytes_q;

  logic launch, hs, last_m, last_n, last_k;
  logic k_step, n_step, m_step, final_hs;
  logic [ADDR_W-1:0] a_ptr, b_ptr, c_ptr;

  assign launch   = start && !busy_q;
  assign hs       = busy_q && cmd_ready;
  assign k_step   = hs && ((stage_q == ST_GEMM && !last_k) || stage_q == ST_WRITE);
  assign n_step   = hs && (stage_q == ST_WRITE);
  assign m_step   = n_step && last_n;
  assign final_hs = m_step && last_m;

  gts_dim_walker #(.DIM_W(DIM_W)) u_walk_m (
    .clk(clk), .rst(rst), .load(launch), .step(m_step),
    .size(dim_m), .tile(tm_c), .is_last(last_m));

  gts_dim_walker #(.DIM_W(DIM_W)) u_walk_n (
    .clk(clk), .rst(rst), .load(launch), .step(n_step),
    .size(dim_n), .tile(tn_c), .is_last(last_n));

  gts_dim_walker #(.DIM_W(DIM_W)) u_walk_k (
    .clk(clk), .rst(rst), .load(launch), .step(k_step),
    .size(dim_k), .tile(tk_c), .is_last(last_k));

  gts_addr_walk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .BPE_W(BPE_W)) u_addr (
    .clk(clk), .rst(rst), .load(launch),
    .a_base(a_base), .b_base(b_base), .c_base(c_base),
    .dim_k(dim_k), .dim_n(dim_n), .tm(tm_c), .tk(tk_c), .tn(tn_c),
    .bpe(elem_bytes), .k_step(k_step), .n_step(n_step), .m_step(m_step),
    .a_ptr(a_ptr), .b_ptr(b_ptr), .c_ptr(c_ptr));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      a_pin_q   <= 1'b0;
      b_pin_q   <= 1'b0;
      stage_q   <= ST_RD_A;
      tile_q    <= '0;
      a_bytes_q <= '0;
      b_bytes_q <= '0;
      c_bytes_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q    <= 1'b1;
        a_pin_q   <= a_resident;
        b_pin_q   <= b_resident;
        stage_q   <= tile_entry(a_resident, b_resident);
        tile_q    <= '0;
        a_bytes_q <= BYTE_W'(tm_c) * BYTE_W'(tk_c) * BYTE_W'(elem_bytes);
        b_bytes_q <= BYTE_W'(tk_c) * BYTE_W'(tn_c) * BYTE_W'(elem_bytes);
        c_bytes_q <= BYTE_W'(tm_c) * BYTE_W'(tn_c) * BYTE_W'(elem_bytes);
      end else if (hs) begin
        case (stage_q)
          ST_RD_A:  stage_q <= b_pin_q ? ST_FETCH : ST_RD_B;
          ST_RD_B:  stage_q <= ST_FETCH;
          ST_FETCH: stage_q <= ST_GEMM;
          ST_GEMM: begin
            if (last_k) begin
              stage_q <= ST_STORE;
            end else begin
              stage_q <= tile_entry(a_pin_q, b_pin_q);
              tile_q  <= tile_q + 1'b1;
            end
          end
          ST_STORE: stage_q <= ST_WRITE;
          default: begin
            if (final_hs) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              stage_q <= tile_entry(a_pin_q, b_pin_q);
              tile_q  <= tile_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    cmd_addr    = '0;
    cmd_bytes   = '0;
    cmd_operand = OPR_NONE;
    case (stage_q)
      ST_RD_A: begin
        cmd_addr    = a_ptr;
        cmd_bytes   = a_bytes_q;
        cmd_operand = OPR_A;
      end
      ST_RD_B: begin
        cmd_addr    = b_ptr;
        cmd_bytes   = b_bytes_q;
        cmd_operand = OPR_B;
      end
      ST_FETCH: cmd_bytes = a_bytes_q + b_bytes_q;
      ST_STORE: cmd_bytes = c_bytes_q;
      ST_WRITE: begin
        cmd_addr  = c_ptr;
        cmd_bytes = c_bytes_q;
      end
      default: cmd_bytes = '0;
    endcase
  end

  assign cmd_valid  = busy_q;
  assign cmd_stage  = stage_q;
  assign cmd_last_k = (stage_q == ST_GEMM) && last_k;
  assign cmd_tile   = tile_q;
  assign done       = done_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_stage) &&
      $stable(cmd_addr) && $stable(cmd_bytes) && $stable(cmd_operand) &&
      $stable(cmd_last_k) && $stable(cmd_tile)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);

  assert_no_read_a_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_stage == 3'(ST_RD_A)) |-> !a_pin_q);

  assert_no_read_b_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_stage == 3'(ST_RD_B)) |-> !b_pin_q);

  assert_fetch_gemm_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_stage == 3'(ST_FETCH)) |=>
      (cmd_valid && cmd_stage == 3'(ST_GEMM)));

  assert_no_early_store_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_stage == 3'(ST_GEMM) && !cmd_last_k) |=>
      (cmd_stage != 3'(ST_STORE)));

  assert_tile_step_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_stage == 3'(ST_GEMM) && !cmd_last_k) |=>
      (cmd_tile == $past(cmd_tile) + 1'b1));

endmodule

// File: tb/sim_gemm_tile_seq.sv
module sim_gemm_tile_seq;
  localparam int DIM_W = 16, ADDR_W = 32, BYTE_W = 32, BPE_W = 4, IDX_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DIM_W-1:0] dim_m = '0, dim_k = '0, dim_n = '0;
  logic [DIM_W-1:0] tile_m = '0, tile_k = '0, tile_n = '0;
  logic [BPE_W-1:0] elem_bytes = '0;
  logic [ADDR_W-1:0] a_base = '0, b_base = '0, c_base = '0;
  logic a_resident = 1'b0, b_resident = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [2:0] cmd_stage;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTE_W-1:0] cmd_bytes;
  logic [1:0] cmd_operand;
  logic cmd_last_k;
  logic [IDX_W-1:0] cmd_tile;
  logic done;

  always #2 clk = ~clk;

  gemm_tile_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
                  .BPE_W(BPE_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n),
    .tile_m(tile_m), .tile_k(tile_k), .tile_n(tile_n),
    .elem_bytes(elem_bytes), .a_base(a_base), .b_base(b_base), .c_base(c_base),
    .a_resident(a_resident), .b_resident(b_resident),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_stage(cmd_stage),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_operand(cmd_operand),
    .cmd_last_k(cmd_last_k), .cmd_tile(cmd_tile), .done(done));

  int checks = 0;
  int fails  = 0;

  int     q_stage[$];
  longint q_addr[$];
  longint q_bytes[$];
  int     q_opr[$];
  int     q_last[$];
  int     q_tile[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int st, input longint ad, input longint by,
                      input int op, input int lk, input int t);
    q_stage.push_back(st);
    q_addr.push_back(ad & 64'hFFFF_FFFF);
    q_bytes.push_back(by & 64'hFFFF_FFFF);
    q_opr.push_back(op);
    q_last.push_back(lk);
    q_tile.push_back(t);
  endtask

  function automatic int ntiles(input int sz, input int t);
    int r;
    r = (sz + t - 1) / t;
    return (r < 1) ? 1 : r;
  endfunction

  // Model walk: ceiling tile counts and direct address formulas.
  task automatic build(input int M, input int K, input int N, input int tm, input int tk,
                       input int tn, input int bpe, input longint ab, input longint bb,
                       input longint cb, input bit ap, input bit bp);
    int tmc, tkc, tnc, mt, kt, nt, t;
    longint abytes, bbytes, cbytes;
    q_stage.delete(); q_addr.delete(); q_bytes.delete();
    q_opr.delete(); q_last.delete(); q_tile.delete();
    tmc = (tm == 0) ? 1 : tm;
    tkc = (tk == 0) ? 1 : tk;
    tnc = (tn == 0) ? 1 : tn;
    mt = ntiles(M, tmc); kt = ntiles(K, tkc); nt = ntiles(N, tnc);
    abytes = longint'(tmc) * tkc * bpe;
    bbytes = longint'(tkc) * tnc * bpe;
    cbytes = longint'(tmc) * tnc * bpe;
    t = 0;
    for (int m = 0; m < mt; m++) begin
      for (int n = 0; n < nt; n++) begin
        for (int k = 0; k < kt; k++) begin
          if (!ap) push(0, ab + (longint'(m) * tmc * K + longint'(k) * tkc) * bpe, abytes, 1, 0, t);
          if (!bp) push(1, bb + (longint'(k) * tkc * N + longint'(n) * tnc) * bpe, bbytes, 2, 0, t);
          push(2, 0, abytes + bbytes, 0, 0, t);
          push(3, 0, 0, 0, (k == kt - 1) ? 1 : 0, t);
          if (k == kt - 1) begin
            push(4, 0, cbytes, 0, 0, t);
            push(5, cb + (longint'(m) * tmc * N + longint'(n) * tnc) * bpe, cbytes, 0, 0, t);
          end
          t++;
        end
      end
    end
  endtask

  task automatic run_case(input int M, input int K, input int N, input int tm, input int tk,
                          input int tn, input int bpe, input longint ab, input longint bb,
                          input longint cb, input bit ap, input bit bp,
                          input int rdy_pct, input int poke_at);
    int idx, total;
    bit hold, poked, restore;
    int h_stage, h_opr, h_last, h_tile;
    longint h_addr, h_bytes;
    build(M, K, N, tm, tk, tn, bpe, ab, bb, cb, ap, bp);
    total = q_stage.size();
    dim_m = DIM_W'(M); dim_k = DIM_W'(K); dim_n = DIM_W'(N);
    tile_m = DIM_W'(tm); tile_k = DIM_W'(tk); tile_n = DIM_W'(tn);
    elem_bytes = BPE_W'(bpe);
    a_base = ADDR_W'(ab); b_base = ADDR_W'(bb); c_base = ADDR_W'(cb);
    a_resident = ap; b_resident = bp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; hold = 0; poked = 0; restore = 0;
    while (idx < total) begin
      if (restore) begin
        start = 1'b0;
        dim_m = DIM_W'(M);
        a_resident = ap;
        restore = 0;
      end
      if (!poked && idx == poke_at) begin
        start = 1'b1;               // R11: start during a run must be ignored
        dim_m = DIM_W'(M + 5);
        a_resident = ~ap;
        poked = 1; restore = 1;
      end
      cmd_ready = (($urandom % 100) < rdy_pct);
      if (hold) begin
        chk(cmd_valid == 1'b1, "R10 stalled valid", longint'(cmd_valid), 1);
        chk(int'(cmd_stage) == h_stage && longint'(cmd_addr) == h_addr &&
            longint'(cmd_bytes) == h_bytes && int'(cmd_operand) == h_opr &&
            int'(cmd_last_k) == h_last && int'(cmd_tile) == h_tile,
            "R10 stalled fields", longint'(cmd_addr), h_addr);
        hold = 0;
      end
      if (cmd_valid) begin
        if (cmd_ready) begin
          chk(int'(cmd_stage) == q_stage[idx], "R3 R4 stage", cmd_stage, q_stage[idx]);
          chk(int'(cmd_operand) == q_opr[idx], "R3 operand", cmd_operand, q_opr[idx]);
          if (q_stage[idx] == 5)
            chk(longint'(cmd_addr) == q_addr[idx], "R6 write address", cmd_addr, q_addr[idx]);
          else
            chk(longint'(cmd_addr) == q_addr[idx], "R5 R2 address", cmd_addr, q_addr[idx]);
          chk(longint'(cmd_bytes) == q_bytes[idx], "R7 bytes", cmd_bytes, q_bytes[idx]);
          chk(int'(cmd_last_k) == q_last[idx], "R8 last_k", cmd_last_k, q_last[idx]);
          chk(int'(cmd_tile) == q_tile[idx], "R9 R2 tile index", cmd_tile, q_tile[idx]);
          idx++;
        end else begin
          hold = 1;
          h_stage = int'(cmd_stage); h_addr = longint'(cmd_addr);
          h_bytes = longint'(cmd_bytes); h_opr = int'(cmd_operand);
          h_last = int'(cmd_last_k); h_tile = int'(cmd_tile);
        end
      end
      @(negedge clk);
    end
    if (restore) begin
      start = 1'b0;
      dim_m = DIM_W'(M);
      a_resident = ap;
    end
    cmd_ready = 1'b0;
    chk(done == 1'b1, "R11 done after final write", done, 1);
    chk(cmd_valid == 1'b0, "R1 R11 no extra command", cmd_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    chk(cmd_valid == 1'b0, "R1 idle after run", cmd_valid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R11 reset valid", cmd_valid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R11 idle before start", cmd_valid, 0);

    // Even split, no residency, with a start poke mid-run (R11).
    run_case(8, 8, 8, 4, 4, 4, 2, 64'h1000, 64'h8000, 64'h2_0000, 0, 0, 70, 9);
    // Remainders on every dimension, A resident (R1, R4).
    run_case(5, 7, 3, 2, 3, 2, 4, 64'h400, 64'h9000, 64'hC000, 1, 0, 60, -1);
    // All sizes zero: one tile of each (R1).
    run_case(0, 0, 0, 4, 4, 4, 1, 64'h10, 64'h20, 64'h30, 0, 0, 100, -1);
    // Zero tile sizes behave as one, B resident (R1, R4).
    run_case(2, 3, 2, 0, 0, 0, 2, 64'h100, 64'h200, 64'h300, 0, 1, 50, -1);
    // Both resident, full throughput (R4).
    run_case(6, 9, 4, 3, 2, 4, 8, 64'h5000, 64'h6000, 64'h7000, 1, 1, 100, 3);
    // Address wrap at the top of the space (R5, R6).
    run_case(4, 4, 4, 2, 2, 2, 4, 64'hFFFF_FFF0, 64'hFFFF_FF00, 64'hFFFF_FFE0, 0, 0, 80, -1);
    // Single K tile covering everything: every GEMM is last (R8).
    run_case(4, 3, 4, 2, 8, 2, 2, 64'h0, 64'h100, 64'h200, 0, 0, 40, -1);

    for (int r = 0; r < 8; r++) begin
      int M, K, N, tm, tk, tn, bpe;
      M = $urandom % 13; K = $urandom % 13; N = $urandom % 13;
      tm = 2 + $urandom % 5; tk = 2 + $urandom % 5; tn = 2 + $urandom % 5;
      bpe = 1 + $urandom % 8;
      run_case(M, K, N, tm, tk, tn, bpe,
               longint'($urandom), longint'($urandom), longint'($urandom),
               bit'($urandom % 2), bit'($urandom % 2), 30 + $urandom % 71,
               int'($urandom % 20));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule